// File: doc/BRIEF.md
# Vertical Line Counter with Non-Linear Readable Count

This block tracks the scan line within a 262-line progressive frame that has 224 visible lines. The horizontal timing generator pulses `line_adv` once per line, and on that clock edge the block steps to the next line. Software-visible logic reads an 8-bit line count that does not climb steadily. It counts up to 0xEA, drops back to 0xE5 and climbs to 0xFF before it wraps. Count values from 0xE5 to 0xEA therefore appear twice in each frame.

A private line index from 0 to 261 holds the true position. The readable count, the one-hot frame region, the vertical-blank flag, the vertical-interrupt enable and a frame-start pulse all come from that index. The horizontal generator uses the interrupt enable to decide on which line a vertical interrupt may fire. Downstream video logic uses the region bits and the frame-start pulse.

Top module: `vline_counter`

## Requirements
- R1: While reset is held, and right after it, `vcount` is 0x00, `region_hot` is 6'b000001, and `vblank`, `vint_en` and `frame_start` are 0.
- R2: The line advances by exactly one on each rising clock edge where `line_adv` is 1, including on back-to-back cycles. With `line_adv` at 0 every output holds its value.
- R3: Over lines 0 to 261, `vcount` reads 0x00 to 0xEA in sequence and then 0xE5 to 0xFF. The 262nd advance returns it to 0x00.
- R4: `region_hot` has exactly one bit set. Bit 0 means active (lines 0-223). Bit 1 means bottom border (224-231). Bit 2 means bottom blanking (232-234). Bit 3 means vertical sync (235-237). Bit 4 means top blanking (238-250). Bit 5 means top border (251-261).
- R5: `vblank` goes to 1 on the line whose count is 0xE0 (line 224). It stays at 1 through both passes of the repeated counts and goes to 0 when the count wraps to 0x00.
- R6: `vint_en` is 1 only during line 224 (count 0xE0) and is 0 on every other line.
- R7: `frame_start` is 1 for exactly one clock, in the cycle after the advance from line 261 to line 0. It is not raised by reset.
- R8: Vertical sync is active only on the second pass through counts 0xE5-0xE7. On the first pass those same counts report bottom border.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_adv | input | 1 | One-clock pulse that steps to the next line |
| vcount | output | 8 | Readable non-linear line count |
| region_hot | output | 6 | One-hot frame region, with the bit meanings given in R4 |
| vblank | output | 1 | Vertical-blank status flag |
| vint_en | output | 1 | Vertical interrupt allowed on this line |
| frame_start | output | 1 | One-clock pulse on return to line 0 |

## Verification
The properties assume only that `line_adv` is a clean synchronous level. They make no assumption about how often it pulses, because a pulse on every cycle must advance the count just as a lone pulse does. The stimulus drives `line_adv` on the falling edge. It uses both single pulses separated by idle cycles and a continuous run, so the hold rule and the back-to-back stepping are both exercised. Checks of the repeated count values always include the region bits, so that the two passes through 0xE5-0xEA can be told apart.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
   localparam int REG_N = 6;

   // bit positions inside the one-hot region vector (order follows the frame)
   typedef enum int {
      RG_ACTIVE     = 0,
      RG_BOT_BORDER = 1,
      RG_BOT_BLANK  = 2,
      RG_VSYNC      = 3,
      RG_TOP_BLANK  = 4,
      RG_TOP_BORDER = 5
   } region_e;

   typedef logic [REG_N-1:0] region_t;
endpackage

// File: rtl/vlc_line_index.sv
module vlc_line_index #(
   parameter int TOTAL = 262,
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] idx,
   output logic [IDX_W-1:0] idx_nxt,
   output logic             frame_pulse
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

   always_comb begin
      idx_nxt = idx;
      if (adv) idx_nxt = (idx == LAST) ? '0 : idx + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx         <= '0;
         frame_pulse <= 1'b0;
      end else begin
         idx         <= idx_nxt;
         frame_pulse <= adv && (idx == LAST);
      end
   end
endmodule

// File: rtl/vlc_count_map.sv
module vlc_count_map #(
   parameter int IDX_W     = 9,
   parameter int VC_W      = 8,
   parameter int JUMP_FROM = 'hEA,
   parameter int JUMP_TO   = 'hE5,
   parameter bit REG_COUNT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [IDX_W-1:0] idx,
   input  logic [IDX_W-1:0] idx_nxt,
   output logic [VC_W-1:0]  vcount
);
   localparam logic [IDX_W-1:0] FOLD_AT  = IDX_W'(JUMP_FROM);
   localparam logic [IDX_W-1:0] FOLD_OFS = IDX_W'(JUMP_FROM + 1 - JUMP_TO);

   function automatic logic [VC_W-1:0] fold(input logic [IDX_W-1:0] i);
      logic [IDX_W-1:0] t;
      t = (i > FOLD_AT) ? i - FOLD_OFS : i;
      return t[VC_W-1:0];
   endfunction

   generate
      if (REG_COUNT) begin : g_reg
         logic [VC_W-1:0] vc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   vc_q <= '0;
            else if (adv) vc_q <= fold(idx_nxt);
         end
         assign vcount = vc_q;
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, adv, idx_nxt};
         assign vcount    = fold(idx);
      end
   endgenerate
endmodule

// File: rtl/vlc_region_decode.sv
module vlc_region_decode
   import vlc_pkg::*;
#(
   parameter int IDX_W      = 9,
   parameter int ACTIVE     = 224,
   parameter int BOT_BORDER = 8,
   parameter int BOT_BLANK  = 3,
   parameter int VSYNC      = 3,
   parameter int TOP_BLANK  = 13,
   parameter int TOP_BORDER = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [IDX_W-1:0] idx,
   input  logic [IDX_W-1:0] idx_nxt,
   output region_t          region_hot,
   output logic             vblank,
   output logic             vint_en
);
   localparam int E1 = ACTIVE;
   localparam int E2 = E1 + BOT_BORDER;
   localparam int E3 = E2 + BOT_BLANK;
   localparam int E4 = E3 + VSYNC;
   localparam int E5 = E4 + TOP_BLANK;
   localparam int E6 = E5 + TOP_BORDER;
   localparam int EDGE [0:REG_N] = '{0, E1, E2, E3, E4, E5, E6};
   localparam logic [IDX_W-1:0] VBL_LINE = IDX_W'(ACTIVE);

   genvar k;
   generate
      for (k = 0; k < REG_N; k++) begin : g_rg
         if (k == 0) begin : g_first
            assign region_hot[k] = idx < IDX_W'(EDGE[1]);
         end else begin : g_mid
            assign region_hot[k] = (idx >= IDX_W'(EDGE[k])) && (idx < IDX_W'(EDGE[k+1]));
         end
      end
   endgenerate

   assign vint_en = (idx == VBL_LINE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vblank <= 1'b0;
      end else if (adv) begin
         if (idx_nxt == VBL_LINE) vblank <= 1'b1;
         else if (idx_nxt == '0)  vblank <= 1'b0;
      end
   end
endmodule

// File: rtl/vline_counter.sv
module vline_counter
   import vlc_pkg::*;
#(
   parameter int ACTIVE     = 224,
   parameter int BOT_BORDER = 8,
   parameter int BOT_BLANK  = 3,
   parameter int VSYNC      = 3,
   parameter int TOP_BLANK  = 13,
   parameter int TOP_BORDER = 11,
   parameter int VC_W       = 8,
   parameter int JUMP_FROM  = 'hEA,
   parameter int JUMP_TO    = 'hE5,
   parameter bit REG_COUNT  = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            line_adv,
   output logic [VC_W-1:0] vcount,
   output logic [5:0]      region_hot,
   output logic            vblank,
   output logic            vint_en,
   output logic            frame_start
);
   localparam int TOTAL = ACTIVE + BOT_BORDER + BOT_BLANK + VSYNC + TOP_BLANK + TOP_BORDER;
   localparam int IDX_W = $clog2(TOTAL);

   generate
      if ((JUMP_FROM + 1) + ((1 << VC_W) - JUMP_TO) != TOTAL) begin : g_bad_fold
         $error("count fold does not cover the frame length");
      end
      if (JUMP_TO > JUMP_FROM || ACTIVE > JUMP_FROM) begin : g_bad_jump
         $error("jump target or active length out of range");
      end
      if (JUMP_FROM + 1 != ACTIVE + BOT_BORDER + BOT_BLANK) begin : g_bad_sync
         $error("sync must start on the first line after the jump");
      end
      if (REG_N != 6) begin : g_bad_regions
         $error("region vector width mismatch");
      end
   endgenerate

   logic [IDX_W-1:0] idx, idx_nxt;
   region_t          rg;

   vlc_line_index #(.TOTAL(TOTAL), .IDX_W(IDX_W)) u_idx (
      .clk(clk), .rst_n(rst_n), .adv(line_adv),
      .idx(idx), .idx_nxt(idx_nxt), .frame_pulse(frame_start)
   );

   vlc_count_map #(
      .IDX_W(IDX_W), .VC_W(VC_W), .JUMP_FROM(JUMP_FROM),
      .JUMP_TO(JUMP_TO), .REG_COUNT(REG_COUNT)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .adv(line_adv),
      .idx(idx), .idx_nxt(idx_nxt), .vcount(vcount)
   );

   vlc_region_decode #(
      .IDX_W(IDX_W), .ACTIVE(ACTIVE), .BOT_BORDER(BOT_BORDER), .BOT_BLANK(BOT_BLANK),
      .VSYNC(VSYNC), .TOP_BLANK(TOP_BLANK), .TOP_BORDER(TOP_BORDER)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .adv(line_adv), .idx(idx), .idx_nxt(idx_nxt),
      .region_hot(rg), .vblank(vblank), .vint_en(vint_en)
   );

   assign region_hot = rg;
endmodule

// File: rtl/vline_counter_chk.sv
module vline_counter_chk #(
   parameter int VC_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            line_adv,
   input logic [VC_W-1:0] vcount,
   input logic [5:0]      region_hot,
   input logic            vblank,
   input logic            vint_en,
   input logic            frame_start
);
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !line_adv |=> ($stable(vcount) && $stable(region_hot) && $stable(vblank)));

   assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_adv && region_hot[2] && vcount == 8'hEA) |=> vcount == 8'hE5);

   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_adv && vcount == 8'hFF) |=> (vcount == 8'h00 && frame_start));

   assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(region_hot) == 1);

   assert_vblank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vblank == !region_hot[0]);

   assert_vint_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vint_en |-> (vcount == 8'hE0 && region_hot[1]));

   assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   assert_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
      region_hot[3] |-> (vcount >= 8'hE5 && vcount <= 8'hE7));
endmodule

bind vline_counter vline_counter_chk #(.VC_W(VC_W)) i_chk (.*);

// File: tb/test_vline_counter.sv
module test_vline_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_adv = 1'b0;
   logic [7:0] vcount;
   logic [5:0] region_hot;
   logic       vblank, vint_en, frame_start;

   int tests = 0;
   int fails = 0;
   int cur   = 0;
   int cycles = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   vline_counter i_vline_counter (
      .clk(clk), .rst_n(rst_n), .line_adv(line_adv), .vcount(vcount),
      .region_hot(region_hot), .vblank(vblank), .vint_en(vint_en),
      .frame_start(frame_start)
   );

   // {line[8:0], vcount[7:0], region[5:0], vblank, vint}
   localparam int NV = 16;
   localparam logic [24:0] VEC [0:NV-1] = '{
      {9'd0,   8'h00, 6'b000001, 1'b0, 1'b0},
      {9'd1,   8'h01, 6'b000001, 1'b0, 1'b0},
      {9'd223, 8'hDF, 6'b000001, 1'b0, 1'b0},
      {9'd224, 8'hE0, 6'b000010, 1'b1, 1'b1},
      {9'd225, 8'hE1, 6'b000010, 1'b1, 1'b0},
      {9'd229, 8'hE5, 6'b000010, 1'b1, 1'b0},
      {9'd231, 8'hE7, 6'b000010, 1'b1, 1'b0},
      {9'd232, 8'hE8, 6'b000100, 1'b1, 1'b0},
      {9'd234, 8'hEA, 6'b000100, 1'b1, 1'b0},
      {9'd235, 8'hE5, 6'b001000, 1'b1, 1'b0},
      {9'd237, 8'hE7, 6'b001000, 1'b1, 1'b0},
      {9'd238, 8'hE8, 6'b010000, 1'b1, 1'b0},
      {9'd240, 8'hEA, 6'b010000, 1'b1, 1'b0},
      {9'd250, 8'hF4, 6'b010000, 1'b1, 1'b0},
      {9'd251, 8'hF5, 6'b100000, 1'b1, 1'b0},
      {9'd261, 8'hFF, 6'b100000, 1'b1, 1'b0}
   };

   task automatic check(input bit ok, input string req, input int got, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) line_adv = 1'b1;
         @(negedge clk) line_adv = 1'b0;
         cur = (cur + 1) % 262;
      end
   endtask

   function automatic int model_vc(input int l);
      return (l < 235) ? l : l - 235 + 'hE5;
   endfunction

   function automatic int model_rg(input int l);
      if (l < 224) return 1;
      if (l < 232) return 2;
      if (l < 235) return 4;
      if (l < 238) return 8;
      if (l < 251) return 16;
      return 32;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         fails++; tests++;
         $display("FAIL watchdog: got 0x%0h expected 0x0", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int vint_lines, sync_lines, pulses, seq_bad, hold_vc;
      repeat (3) @(negedge clk);
      // R1: state while reset is held
      check(vcount == 8'h00 && region_hot == 6'b000001 && !vblank && !vint_en && !frame_start,
            "R1 reset", {vcount, region_hot}, {8'h00, 6'b000001});
      rst_n = 1'b1;
      @(negedge clk);
      check(!frame_start && vcount == 8'h00, "R1 after release", frame_start, 0);

      // table walk: R3 R4 R5 R6 R8
      for (int v = 0; v < NV; v++) begin
         step(int'(VEC[v][24:16]) - cur);
         check(vcount == VEC[v][15:8], "R3 count", vcount, VEC[v][15:8]);
         check(region_hot == VEC[v][7:2], "R4/R8 region", region_hot, VEC[v][7:2]);
         check(vblank == VEC[v][1], "R5 vblank", vblank, VEC[v][1]);
         check(vint_en == VEC[v][0], "R6 vint", vint_en, VEC[v][0]);
      end

      // R7: wrap from 261 to 0 gives one pulse
      step(1);
      check(vcount == 8'h00 && region_hot == 6'b000001, "R3 wrap", vcount, 0);
      check(!vblank, "R5 clear at wrap", vblank, 0);
      check(frame_start, "R7 pulse high", frame_start, 1);
      @(negedge clk);
      check(!frame_start, "R7 pulse one clock", frame_start, 0);

      // R2: idle cycles hold state
      step(5);
      hold_vc = vcount;
      repeat (7) @(negedge clk);
      check(vcount == hold_vc && region_hot == 6'b000001, "R2 hold", vcount, hold_vc);

      // R2: back-to-back advances, one per clock
      @(negedge clk) line_adv = 1'b1;
      repeat (4) @(negedge clk);
      line_adv = 1'b0;
      cur += 4;
      check(vcount == model_vc(cur), "R2 back-to-back", vcount, model_vc(cur));

      // full frame sweep against model: R3 R4 R6 R7 R8
      vint_lines = 0; sync_lines = 0; pulses = 0; seq_bad = 0;
      for (int n = 0; n < 262; n++) begin
         step(1);
         if (frame_start) pulses++;
         if (vint_en) vint_lines++;
         if (region_hot[3]) sync_lines++;
         if (vcount != model_vc(cur) || region_hot != model_rg(cur)) seq_bad++;
      end
      check(seq_bad == 0, "R3/R4 full frame", seq_bad, 0);
      check(vint_lines == 1, "R6 one line per frame", vint_lines, 1);
      check(sync_lines == 3, "R8 sync length", sync_lines, 3);
      check(pulses == 1, "R7 one pulse per frame", pulses, 1);

      // R1: reset mid-frame
      step(240 - cur);
      check(vcount == 8'hEA && region_hot == 6'b010000, "R8 second EA", vcount, 'hEA);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      check(vcount == 8'h00 && !vblank && region_hot == 6'b000001 && !frame_start,
            "R1 mid-frame reset", vcount, 0);
      rst_n = 1'b1;
      cur = 0;
      step(1);
      check(vcount == 8'h01, "R2 step after reset", vcount, 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule